// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the host side of an SMBus controller. Software programs a small byte-wide register file with a target address, a command byte and up to two data bytes. It then writes a protocol code, and that write starts a complete bus transaction. The sequencer splits the transaction into byte-level steps and hands them one at a time to an I2C master engine. The steps are start, write byte, read byte, repeated start and stop. When the last step has finished, the block posts a status byte, stores any received bytes in the data registers, clears the protocol register and pulses a completion output.

The protocol code combines a transfer kind in bits 7:1 with a direction flag in bit 0, where 1 means read. The supported kinds are quick (0x02/0x03), send/receive byte (0x04/0x05), byte-data (0x06/0x07) and word-data (0x08/0x09). Any other nonzero code is refused and completes at once with an error. This includes block kinds, process calls and any code with bit 7 set.

The controller is built around one state machine with these states: IDLE, START, ADDR, CMD, WR, RSTART, ADDR_RD, RD, STOP and FINISH. Its transitions are as follows.
- IDLE goes to START when a supported code is launched, and to FINISH when an unsupported code is launched.
- START goes to ADDR.
- ADDR goes to STOP for a quick transfer, to RD for a receive byte, and to CMD for every other kind.
- CMD goes to STOP for a send byte, to WR for a data write, and to RSTART for a data read.
- WR loops on itself until the last data byte, then goes to STOP.
- RSTART goes to ADDR_RD, and ADDR_RD goes to RD.
- RD loops on itself until the last byte, then goes to STOP.
- ADDR or ADDR_RD goes to STOP when the address is not acknowledged. CMD or WR goes to STOP when a byte is not acknowledged.
- STOP goes to FINISH, and FINISH always returns to IDLE.

Top module: `smb_host_seq`

## Requirements
- R1: Registers sit at these byte offsets: protocol 0x00, status 0x01, target address 0x02, command 0x03, data0 0x04 and data1 0x05. The address, command and data registers read back what was written. Any other offset reads 0x00, and all registers reset to 0x00.
- R2: A nonzero write to the protocol register while the block is idle starts a transaction. From the next cycle the status register reads 0x00 and the protocol register reads the written code until completion.
- R3: When a transaction completes, `xfer_done` is high for exactly one cycle. From the following cycle the protocol register reads 0x00 and status reads {done=1 in bit 7, alarm=0 in bit 6, reserved 0 in bit 5, error code in bits 4:0}.
- R4: Every address byte on the master port is {target address register bits 7:1, R/W}. The sequencer supplies R/W itself and ignores bit 0 of the register.
- R5: A quick transfer issues start, then the address byte with R/W equal to code bit 0, then stop.
- R6: A send byte issues start, address+W, command, stop. A receive byte issues start, address+R, one read with NACK, stop, and stores the received byte in data0.
- R7: Byte-data and word-data writes issue start, address+W, command, data0, then data1 for word-data only, then stop.
- R8: Byte-data and word-data reads issue start, address+W, command, repeated start, address+R, then one or two reads, then stop. Every read is ACKed except the last, which is NACKed. The bytes land in data0 and data1.
- R9: A missing acknowledge on either address byte gives error code 0x10. Stop is issued and the transaction then completes.
- R10: A missing acknowledge on the command byte or a data byte gives error code 0x11. No further bytes are sent, stop is issued, and the transaction completes.
- R11: An unsupported nonzero code completes with error code 0x1F. No command is sent to the master port.
- R12: A protocol-register write made while a transaction is pending or in flight is ignored. It changes neither the stored code nor the bytes sent.
- R13: Master port encoding of `bm_cmd_op` is 0 start, 1 write byte, 2 read byte, 3 repeated start, 4 stop. A command is accepted on `bm_cmd_valid && bm_cmd_ready` and is held stable until then. Each command is answered by exactly one `bm_rsp_valid` before the next command is offered. For writes, `bm_rsp_ack` high means acknowledged. For reads, `bm_rsp_rdata` carries the byte and `bm_cmd_nack` selects NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | REG_AW | Register write offset |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | REG_AW | Register read offset |
| reg_rd_data | output | 8 | Register read data (combinational) |
| xfer_done | output | 1 | One-cycle completion pulse |
| bm_cmd_valid | output | 1 | Master command valid |
| bm_cmd_ready | input | 1 | Master command ready |
| bm_cmd_op | output | 3 | Master command opcode |
| bm_cmd_wdata | output | 8 | Byte to write |
| bm_cmd_nack | output | 1 | NACK the byte being read |
| bm_rsp_valid | input | 1 | Master response valid |
| bm_rsp_ack | input | 1 | Target acknowledged the written byte |
| bm_rsp_rdata | input | 8 | Byte received by a read |

## Verification
A wrong state or branch shows up on the master port within a single command. The command after the faulty decision has the wrong opcode, the wrong byte or the wrong ACK/NACK choice, or the stop comes too early or too late. The bench therefore logs every accepted command and compares the whole log with a model built from the protocol code. A corrupted error or index register appears only at completion, in the status byte and in the data registers. Those are read one cycle after the `xfer_done` pulse, and the length of that pulse is also checked.

// File: rtl/smb_host_pkg.sv
`timescale 1ns/1ps
package smb_host_pkg;
    typedef enum logic [2:0] {
        BOP_START  = 3'd0,
        BOP_WRITE  = 3'd1,
        BOP_READ   = 3'd2,
        BOP_RSTART = 3'd3,
        BOP_STOP   = 3'd4
    } bop_e;

    typedef enum logic [1:0] {
        XK_QUICK,
        XK_BYTE,
        XK_BDATA,
        XK_WDATA
    } xkind_e;

    localparam logic [4:0] ERR_NONE      = 5'h00;
    localparam logic [4:0] ERR_ADDR_NACK = 5'h10;
    localparam logic [4:0] ERR_DATA_NACK = 5'h11;
    localparam logic [4:0] ERR_BAD_PROTO = 5'h1F;

    // byte offsets decoded by software
    localparam int unsigned OFS_PROTO = 0;
    localparam int unsigned OFS_STAT  = 1;
    localparam int unsigned OFS_TADDR = 2;
    localparam int unsigned OFS_CMD   = 3;
    localparam int unsigned OFS_DATA0 = 4;
endpackage

// File: rtl/smb_proto_dec.sv
`timescale 1ns/1ps
module smb_proto_dec
    import smb_host_pkg::*;
(
    input  logic [7:0] code_i,
    output logic       supported_o,
    output logic       is_read_o,
    output xkind_e     kind_o
);
    always_comb begin
        supported_o = 1'b1;
        kind_o      = XK_QUICK;
        is_read_o   = code_i[0];
        unique case (code_i[7:1])
            7'h01:   kind_o = XK_QUICK;
            7'h02:   kind_o = XK_BYTE;
            7'h03:   kind_o = XK_BDATA;
            7'h04:   kind_o = XK_WDATA;
            default: supported_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/smb_regs.sv
`timescale 1ns/1ps
module smb_regs
    import smb_host_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int N_DATA = 2,
    localparam int IDX_W = (N_DATA > 1) ? $clog2(N_DATA) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [REG_AW-1:0]      wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic [REG_AW-1:0]      rd_addr_i,
    output logic [7:0]             rd_data_o,
    input  logic                   fsm_busy_i,
    input  logic                   fin_i,
    input  logic [4:0]             fin_err_i,
    input  logic                   cap_valid_i,
    input  logic [IDX_W-1:0]       cap_idx_i,
    input  logic [7:0]             cap_data_i,
    output logic                   launch_o,
    output logic [7:0]             proto_o,
    output logic [7:0]             taddr_o,
    output logic [7:0]             cmd_o,
    output logic [N_DATA-1:0][7:0] data_o
);
    logic [7:0] proto_q, status_q, taddr_q, cmd_q;
    logic [N_DATA-1:0][7:0] data_q;
    logic launch_q;
    logic busy;
    logic proto_wr;
    logic accept;

    assign busy     = launch_q || fsm_busy_i;
    assign proto_wr = wr_en_i && (wr_addr_i == REG_AW'(OFS_PROTO));
    assign accept   = proto_wr && (wr_data_i != 8'h00) && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_q  <= '0;
            status_q <= '0;
            taddr_q  <= '0;
            cmd_q    <= '0;
            data_q   <= '0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= accept;
            if (accept) begin
                proto_q  <= wr_data_i;
                status_q <= '0;
            end else if (fin_i) begin
                proto_q  <= '0;
                status_q <= {1'b1, 2'b00, fin_err_i};
            end
            if (wr_en_i && wr_addr_i == REG_AW'(OFS_TADDR)) taddr_q <= wr_data_i;
            if (wr_en_i && wr_addr_i == REG_AW'(OFS_CMD))   cmd_q   <= wr_data_i;
            for (int i = 0; i < N_DATA; i++) begin
                if (cap_valid_i && cap_idx_i == IDX_W'(i))
                    data_q[i] <= cap_data_i;
                else if (wr_en_i && wr_addr_i == REG_AW'(OFS_DATA0 + i))
                    data_q[i] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == REG_AW'(OFS_PROTO)) rd_data_o = proto_q;
        if (rd_addr_i == REG_AW'(OFS_STAT))  rd_data_o = status_q;
        if (rd_addr_i == REG_AW'(OFS_TADDR)) rd_data_o = taddr_q;
        if (rd_addr_i == REG_AW'(OFS_CMD))   rd_data_o = cmd_q;
        for (int i = 0; i < N_DATA; i++)
            if (rd_addr_i == REG_AW'(OFS_DATA0 + i)) rd_data_o = data_q[i];
    end

    assign launch_o = launch_q;
    assign proto_o  = proto_q;
    assign taddr_o  = taddr_q;
    assign cmd_o    = cmd_q;
    assign data_o   = data_q;

    assert_launch_clears_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (status_q == 8'h00) && (proto_q == $past(wr_data_i)));

    assert_fin_clears_proto_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> (proto_q == 8'h00) && status_q[7] && !status_q[6]);

    assert_busy_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_wr && busy && !fin_i) |=> (proto_q == $past(proto_q)));
endmodule

// File: rtl/smb_seq_fsm.sv
`timescale 1ns/1ps
module smb_seq_fsm
    import smb_host_pkg::*;
#(
    parameter int N_DATA = 2,
    localparam int IDX_W = (N_DATA > 1) ? $clog2(N_DATA) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch_i,
    input  logic                   supported_i,
    input  logic                   is_read_i,
    input  xkind_e                 kind_i,
    input  logic [6:0]             taddr_i,
    input  logic [7:0]             cmd_i,
    input  logic [N_DATA-1:0][7:0] data_i,
    output logic                   cmd_valid_o,
    input  logic                   cmd_ready_i,
    output logic [2:0]             cmd_op_o,
    output logic [7:0]             cmd_wdata_o,
    output logic                   cmd_nack_o,
    input  logic                   rsp_valid_i,
    input  logic                   rsp_ack_i,
    input  logic [7:0]             rsp_rdata_i,
    output logic                   busy_o,
    output logic                   fin_o,
    output logic [4:0]             fin_err_o,
    output logic                   cap_valid_o,
    output logic [IDX_W-1:0]       cap_idx_o,
    output logic [7:0]             cap_data_o
);
    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_CMD, ST_WR,
        ST_RSTART, ST_ADDR_RD, ST_RD, ST_STOP, ST_FINISH
    } state_e;

    state_e state_q, state_d;
    logic waiting_q, waiting_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [4:0] err_q, err_d;
    logic rsp_fire;
    logic [IDX_W-1:0] last_idx;
    bop_e op;

    assign rsp_fire = rsp_valid_i && waiting_q;
    assign last_idx = (kind_i == XK_WDATA) ? IDX_W'(1) : '0;

    // next-state process
    always_comb begin
        state_d   = state_q;
        waiting_d = waiting_q;
        idx_d     = idx_q;
        err_d     = err_q;
        if (cmd_valid_o && cmd_ready_i) waiting_d = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                if (launch_i) begin
                    idx_d = '0;
                    if (supported_i) begin
                        state_d = ST_START;
                        err_d   = ERR_NONE;
                    end else begin
                        state_d = ST_FINISH;
                        err_d   = ERR_BAD_PROTO;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default: begin
                if (rsp_fire) begin
                    waiting_d = 1'b0;
                    case (state_q)
                        ST_START: state_d = ST_ADDR;
                        ST_ADDR: begin
                            if (!rsp_ack_i) begin
                                err_d = ERR_ADDR_NACK; state_d = ST_STOP;
                            end else if (kind_i == XK_QUICK) state_d = ST_STOP;
                            else if (kind_i == XK_BYTE && is_read_i) state_d = ST_RD;
                            else state_d = ST_CMD;
                        end
                        ST_CMD: begin
                            if (!rsp_ack_i) begin
                                err_d = ERR_DATA_NACK; state_d = ST_STOP;
                            end else if (kind_i == XK_BYTE) state_d = ST_STOP;
                            else if (is_read_i) state_d = ST_RSTART;
                            else state_d = ST_WR;
                        end
                        ST_WR: begin
                            if (!rsp_ack_i) begin
                                err_d = ERR_DATA_NACK; state_d = ST_STOP;
                            end else if (idx_q == last_idx) state_d = ST_STOP;
                            else idx_d = idx_q + 1'b1;
                        end
                        ST_RSTART: state_d = ST_ADDR_RD;
                        ST_ADDR_RD: begin
                            if (!rsp_ack_i) begin
                                err_d = ERR_ADDR_NACK; state_d = ST_STOP;
                            end else state_d = ST_RD;
                        end
                        ST_RD: begin
                            if (idx_q == last_idx) state_d = ST_STOP;
                            else idx_d = idx_q + 1'b1;
                        end
                        ST_STOP: state_d = ST_FINISH;
                        default: state_d = state_q;
                    endcase
                end
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            waiting_q <= 1'b0;
            idx_q     <= '0;
            err_q     <= ERR_NONE;
        end else begin
            state_q   <= state_d;
            waiting_q <= waiting_d;
            idx_q     <= idx_d;
            err_q     <= err_d;
        end
    end

    // output process
    always_comb begin
        op          = BOP_START;
        cmd_valid_o = 1'b0;
        cmd_wdata_o = 8'h00;
        cmd_nack_o  = 1'b0;
        unique case (state_q)
            ST_START:   begin op = BOP_START;  cmd_valid_o = !waiting_q; end
            ST_ADDR:    begin
                op = BOP_WRITE; cmd_valid_o = !waiting_q;
                cmd_wdata_o = {taddr_i, is_read_i && (kind_i == XK_QUICK || kind_i == XK_BYTE)};
            end
            ST_CMD:     begin op = BOP_WRITE;  cmd_valid_o = !waiting_q; cmd_wdata_o = cmd_i; end
            ST_WR:      begin op = BOP_WRITE;  cmd_valid_o = !waiting_q; cmd_wdata_o = data_i[idx_q]; end
            ST_RSTART:  begin op = BOP_RSTART; cmd_valid_o = !waiting_q; end
            ST_ADDR_RD: begin op = BOP_WRITE;  cmd_valid_o = !waiting_q; cmd_wdata_o = {taddr_i, 1'b1}; end
            ST_RD:      begin op = BOP_READ;   cmd_valid_o = !waiting_q; cmd_nack_o = (idx_q == last_idx); end
            ST_STOP:    begin op = BOP_STOP;   cmd_valid_o = !waiting_q; end
            default:    ;
        endcase
    end

    assign cmd_op_o    = op;
    assign busy_o      = (state_q != ST_IDLE);
    assign fin_o       = (state_q == ST_FINISH);
    assign fin_err_o   = err_q;
    assign cap_valid_o = (state_q == ST_RD) && rsp_fire;
    assign cap_idx_o   = idx_q;
    assign cap_data_o  = rsp_rdata_i;

    assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_op_o)
            && $stable(cmd_wdata_o) && $stable(cmd_nack_o));

    assert_no_cmd_while_waiting_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i) |=> !cmd_valid_o);

    assert_stop_before_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_o && err_q != ERR_NONE && err_q != ERR_BAD_PROTO) |-> $past(state_q) == ST_STOP);

    assert_err_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> (err_q == ERR_NONE || err_q == ERR_ADDR_NACK
                   || err_q == ERR_DATA_NACK || err_q == ERR_BAD_PROTO));
endmodule

// File: rtl/smb_host_seq.sv
`timescale 1ns/1ps
module smb_host_seq
    import smb_host_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int N_DATA = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_wr_addr,
    input  logic [7:0]        reg_wr_data,
    input  logic [REG_AW-1:0] reg_rd_addr,
    output logic [7:0]        reg_rd_data,
    output logic              xfer_done,
    output logic              bm_cmd_valid,
    input  logic              bm_cmd_ready,
    output logic [2:0]        bm_cmd_op,
    output logic [7:0]        bm_cmd_wdata,
    output logic              bm_cmd_nack,
    input  logic              bm_rsp_valid,
    input  logic              bm_rsp_ack,
    input  logic [7:0]        bm_rsp_rdata
);
    localparam int IDX_W = (N_DATA > 1) ? $clog2(N_DATA) : 1;

    logic launch, fsm_busy, fin, cap_valid, supported, is_read;
    logic [4:0] fin_err;
    logic [IDX_W-1:0] cap_idx;
    logic [7:0] cap_data, proto, taddr, cmd;
    logic [N_DATA-1:0][7:0] data;
    xkind_e kind;

    smb_regs #(.REG_AW(REG_AW), .N_DATA(N_DATA)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(reg_wr_en), .wr_addr_i(reg_wr_addr), .wr_data_i(reg_wr_data),
        .rd_addr_i(reg_rd_addr), .rd_data_o(reg_rd_data),
        .fsm_busy_i(fsm_busy), .fin_i(fin), .fin_err_i(fin_err),
        .cap_valid_i(cap_valid), .cap_idx_i(cap_idx), .cap_data_i(cap_data),
        .launch_o(launch), .proto_o(proto), .taddr_o(taddr), .cmd_o(cmd), .data_o(data)
    );

    smb_proto_dec dec_i (
        .code_i(proto), .supported_o(supported), .is_read_o(is_read), .kind_o(kind)
    );

    smb_seq_fsm #(.N_DATA(N_DATA)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .launch_i(launch), .supported_i(supported), .is_read_i(is_read), .kind_i(kind),
        .taddr_i(taddr[7:1]), .cmd_i(cmd), .data_i(data),
        .cmd_valid_o(bm_cmd_valid), .cmd_ready_i(bm_cmd_ready), .cmd_op_o(bm_cmd_op),
        .cmd_wdata_o(bm_cmd_wdata), .cmd_nack_o(bm_cmd_nack),
        .rsp_valid_i(bm_rsp_valid), .rsp_ack_i(bm_rsp_ack), .rsp_rdata_i(bm_rsp_rdata),
        .busy_o(fsm_busy), .fin_o(fin), .fin_err_o(fin_err),
        .cap_valid_o(cap_valid), .cap_idx_o(cap_idx), .cap_data_o(cap_data)
    );

    assign xfer_done = fin;
endmodule

// File: tb/smb_host_seq_tb_top.sv
`timescale 1ns/1ps
module smb_host_seq_tb_top;
    localparam int OP_S = 0, OP_W = 1, OP_R = 2, OP_RS = 3, OP_P = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [5:0] reg_wr_addr = '0, reg_rd_addr = '0;
    logic [7:0] reg_wr_data = '0, reg_rd_data;
    logic xfer_done, bm_cmd_valid, bm_cmd_nack;
    logic bm_cmd_ready = 1'b0, bm_rsp_valid = 1'b0, bm_rsp_ack = 1'b0;
    logic [2:0] bm_cmd_op;
    logic [7:0] bm_cmd_wdata, bm_rsp_rdata = '0;

    smb_host_seq dut_i (.*);

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0;
    logic [6:0] slv_addr;
    int nack_idx;
    logic [7:0] rsrc [2];
    logic [11:0] act_log [16], exp_log [16];
    int act_n, exp_n;
    logic [4:0] exp_err;
    logic [7:0] mdl_d0, mdl_d1;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // target model on the byte-level port
    initial begin
        bit pend = 0, addr_ph = 0;
        int dly = 0, wk = 0, rk = 0;
        logic p_ack = 1'b0;
        logic [7:0] p_rd = '0;
        forever begin
            @(negedge clk);
            bm_rsp_valid = 1'b0;
            if (!rst_n) begin pend = 0; bm_cmd_ready = 1'b0; continue; end
            if (pend) begin
                bm_cmd_ready = 1'b0;
                if (dly == 0) begin
                    bm_rsp_valid = 1'b1; bm_rsp_ack = p_ack; bm_rsp_rdata = p_rd; pend = 0;
                end else dly--;
            end else begin
                bm_cmd_ready = ($urandom % 4) != 0;
                if (bm_cmd_valid && bm_cmd_ready) begin
                    if (act_n < 16)
                        act_log[act_n] = {bm_cmd_op, bm_cmd_op == 3'(OP_R) ? bm_cmd_nack : 1'b0,
                                          bm_cmd_op == 3'(OP_W) ? bm_cmd_wdata : 8'h00};
                    act_n++;
                    p_ack = 1'b1; p_rd = 8'h00;
                    case (int'(bm_cmd_op))
                        OP_S:  begin addr_ph = 1; wk = 0; rk = 0; end
                        OP_RS: addr_ph = 1;
                        OP_W: begin
                            if (addr_ph) begin p_ack = (bm_cmd_wdata[7:1] == slv_addr); addr_ph = 0; end
                            else begin p_ack = (wk != nack_idx); wk++; end
                        end
                        OP_R: begin p_rd = rsrc[rk % 2]; rk++; end
                        default: ;
                    endcase
                    pend = 1; dly = $urandom % 3;
                end
            end
        end
    end

    task automatic push(input int op, input logic nk, input logic [7:0] b);
        exp_log[exp_n] = {3'(op), nk, b};
        exp_n++;
    endtask

    task automatic exp_build(input logic [7:0] code, input logic [7:0] a, input logic [7:0] c,
                             input logic [7:0] d0, input logic [7:0] d1);
        bit ok = (a[7:1] == slv_addr);
        int k = int'(code[7:1]);
        logic rdf = code[0];
        exp_n = 0; exp_err = 5'h00;
        if (k < 1 || k > 4) begin exp_err = 5'h1F; return; end
        push(OP_S, 0, 0);
        if (k == 1) begin
            push(OP_W, 0, {a[7:1], rdf});
            if (!ok) exp_err = 5'h10;
            push(OP_P, 0, 0); return;
        end
        if (k == 2 && rdf) begin
            push(OP_W, 0, {a[7:1], 1'b1});
            if (!ok) begin exp_err = 5'h10; push(OP_P, 0, 0); return; end
            push(OP_R, 1, 0); mdl_d0 = rsrc[0]; push(OP_P, 0, 0); return;
        end
        push(OP_W, 0, {a[7:1], 1'b0});
        if (!ok) begin exp_err = 5'h10; push(OP_P, 0, 0); return; end
        push(OP_W, 0, c);
        if (nack_idx == 0) begin exp_err = 5'h11; push(OP_P, 0, 0); return; end
        if (k == 2) begin push(OP_P, 0, 0); return; end
        if (!rdf) begin
            push(OP_W, 0, d0);
            if (nack_idx == 1) begin exp_err = 5'h11; push(OP_P, 0, 0); return; end
            if (k == 4) begin
                push(OP_W, 0, d1);
                if (nack_idx == 2) exp_err = 5'h11;
            end
            push(OP_P, 0, 0); return;
        end
        push(OP_RS, 0, 0);
        push(OP_W, 0, {a[7:1], 1'b1});
        push(OP_R, k == 3, 0); mdl_d0 = rsrc[0];
        if (k == 4) begin push(OP_R, 1, 0); mdl_d1 = rsrc[1]; end
        push(OP_P, 0, 0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_rd_addr = a; #1; d = reg_rd_data;
    endtask

    function automatic string tag_of(input logic [7:0] code, input logic [4:0] e);
        if (e == 5'h10) return "R9";
        if (e == 5'h11) return "R10";
        if (e == 5'h1F) return "R11";
        case (code[7:1])
            7'h01: return "R5";
            7'h02: return "R6";
            default: return code[0] ? "R8" : "R7";
        endcase
    endfunction

    task automatic run_xfer(input logic [7:0] code, input logic [7:0] a, input logic [7:0] c,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] busy_code);
        logic [7:0] v;
        int n = 0;
        string t;
        wr(6'h02, a); wr(6'h03, c); wr(6'h04, d0); wr(6'h05, d1);
        mdl_d0 = d0; mdl_d1 = d1;
        exp_build(code, a, c, d0, d1);
        t = tag_of(code, exp_err);
        act_n = 0;
        wr(6'h00, code);
        rd(6'h01, v); check("R2", "status after launch", v, 8'h00);
        rd(6'h00, v); check("R2", "protocol in flight", v, code);
        if (busy_code != 8'h00) begin
            wr(6'h00, busy_code);
            rd(6'h00, v); check("R12", "protocol after busy write", v, code);
        end
        while (!xfer_done && n < 2000) begin @(negedge clk); n++; end
        check("R3", "done seen", xfer_done, 1'b1);
        @(negedge clk);
        check("R3", "done one cycle", xfer_done, 1'b0);
        rd(6'h00, v); check("R3", "protocol cleared", v, 8'h00);
        rd(6'h01, v); check(t, "status", v, {3'b100, exp_err});
        rd(6'h04, v); check(t, "data0", v, mdl_d0);
        rd(6'h05, v); check(t, "data1", v, mdl_d1);
        check(t, "command count", act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n && i < 16; i++)
            check(t, $sformatf("command %0d", i), act_log[i], exp_log[i]);
        if (exp_n > 1 && act_n > 1)
            check("R4", "address byte", act_log[1], exp_log[1]);
        if (busy_code != 8'h00)
            check("R12", "sequence unaffected", act_n, exp_n);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] codes [14] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
                                   8'h0A, 8'h0C, 8'h0D, 8'h86, 8'h01, 8'h0B};
        void'($urandom(32'd1234));
        slv_addr = 7'h2A; nack_idx = -1; rsrc[0] = 8'hC3; rsrc[1] = 8'h5E;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        rd(6'h00, v); check("R1", "reset protocol", v, 8'h00);
        rd(6'h01, v); check("R1", "reset status", v, 8'h00);
        rd(6'h04, v); check("R1", "reset data0", v, 8'h00);
        check("R13", "no command after reset", bm_cmd_valid, 1'b0);
        check("R3", "no done after reset", xfer_done, 1'b0);
        // readback and unmapped offset
        wr(6'h02, 8'h55); wr(6'h03, 8'hA7); wr(6'h05, 8'h3C);
        rd(6'h02, v); check("R1", "address readback", v, 8'h55);
        rd(6'h03, v); check("R1", "command readback", v, 8'hA7);
        rd(6'h05, v); check("R1", "data1 readback", v, 8'h3C);
        rd(6'h24, v); check("R1", "unmapped offset", v, 8'h00);
        // zero write does not launch
        wr(6'h00, 8'h00);
        repeat (3) @(negedge clk);
        check("R2", "zero code no command", bm_cmd_valid, 1'b0);
        // directed corners
        run_xfer(8'h09, 8'h55, 8'h10, 8'h11, 8'h22, 8'h00);                 // word read, addr bit0 set
        run_xfer(8'h06, 8'h40, 8'h10, 8'h11, 8'h22, 8'h00);                 // address NACK
        nack_idx = 1; run_xfer(8'h08, 8'h54, 8'h20, 8'h77, 8'h88, 8'h00);   // data0 NACK
        nack_idx = 0; run_xfer(8'h07, 8'h54, 8'h20, 8'h77, 8'h88, 8'h00);   // command NACK on read
        nack_idx = -1;
        run_xfer(8'h0A, 8'h54, 8'h20, 8'h01, 8'h02, 8'h00);                 // unsupported block
        run_xfer(8'h86, 8'h54, 8'h20, 8'h01, 8'h02, 8'h00);                 // PEC requested
        run_xfer(8'h03, 8'h54, 8'h00, 8'h01, 8'h02, 8'h00);                 // quick read
        run_xfer(8'h08, 8'h54, 8'h31, 8'h9A, 8'hBC, 8'h07);                 // write while busy
        // random mix
        for (int j = 0; j < 60; j++) begin
            logic [7:0] a, c, d0, d1;
            int r = $urandom % 10;
            a  = ($urandom % 5 == 0) ? 8'($urandom) : {slv_addr, 1'($urandom)};
            c  = 8'($urandom); d0 = 8'($urandom); d1 = 8'($urandom);
            rsrc[0] = 8'($urandom); rsrc[1] = 8'($urandom);
            nack_idx = (r < 6) ? -1 : (r - 6);
            run_xfer(codes[$urandom % 14], a, c, d0, d1, 8'h00);
        end
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule